// File: doc/BRIEF.md
# Cost-Weighted Recency Victim Selector

This block keeps replacement state for one set of a set-associative cache. For every way it holds a recency rank and a small quantized miss cost. The rank is 0 for the least recently touched way and WAYS-1 for the most recent one. The cost is the 3-bit figure supplied when the way was last filled. From this state it names the way to evict next.

Two selection rules are available. Plain recency picks the way ranked 0. The linear rule adds the way's rank to a programmable weight times its stored cost, and picks the way with the smallest sum. Under the linear rule, a block that was expensive to fetch stays resident longer than its recency alone would allow.

The surrounding cache controller reports hits and fills through two strobes. It reads the victim way combinationally whenever it needs to allocate. Tag matching and data storage belong to the controller and are not part of this block.

Top module: `lru_cost_victim`

## Requirements
- R1: While reset is asserted, and after it is released before any update, way i holds rank i and every stored cost is zero. The victim is therefore way 0 under both rules and any weight.
- R2: A hit (`acc_en`) or a fill (`fill_en`) moves the touched way to rank WAYS-1 (15). Every way whose rank was above the touched way's old rank drops by one, and all other ranks stay unchanged. The change takes effect at the next rising clock edge.
- R3: With `cost_mode` = 0 (plain recency), `victim_way` is the way whose rank is 0.
- R4: With `cost_mode` = 1 (linear rule), `victim_way` is the way with the smallest score rank + `cost_weight` × cost. The score is formed at 7 bits, so the largest value, 15 + 7×7 = 64, does not overflow.
- R5: When several ways share the smallest score, the victim is the lowest-numbered of them.
- R6: A hit leaves every stored cost unchanged. A fill writes `fill_cost` as the new cost of `fill_way` only.
- R7: When `acc_en` and `fill_en` are both high in the same cycle, only the fill takes effect. The hit way is neither moved to the top rank nor otherwise treated as touched.
- R8: `victim_way` is a combinational function of the stored state, `cost_mode` and `cost_weight`. A change of rule or weight shows on the output without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Hit strobe for the way on `acc_way` |
| acc_way | input | 4 | Way that hit |
| fill_en | input | 1 | Fill strobe for the way on `fill_way` |
| fill_way | input | 4 | Way being filled |
| fill_cost | input | 3 | Quantized miss cost stored with the fill |
| cost_mode | input | 1 | 0 selects plain recency, 1 selects the linear rule |
| cost_weight | input | 3 | Weight applied to cost under the linear rule |
| victim_way | output | 4 | Way chosen for eviction |

## Verification
The bench builds the block with its default parameters: 16 ways, 3-bit cost and 3-bit weight. This configuration is small enough that both rules and all eight weights can be compared against an arithmetic model after every single update. A long pseudo-random stream of hits, fills and simultaneous hit-plus-fill cycles, with every cost value drawn, reaches the top score of 64 and produces many equal-score ties. Directed sequences pin down the reset ranking, a forced tie, cost retention across hits, and the precedence of a fill over a concurrent hit.

// File: rtl/lru_cost_pkg.sv
`timescale 1ns/1ps
package lru_cost_pkg;

  typedef enum logic {
    POL_LRU = 1'b0,
    POL_LIN = 1'b1
  } policy_e;

  // Bits needed to hold the largest linear score without overflow.
  function automatic int score_bits(input int ways, input int cost_w, input int wt_w);
    int top;
    int b;
    top = (ways - 1) + ((1 << cost_w) - 1) * ((1 << wt_w) - 1);
    b = 1;
    while ((1 << b) <= top) b++;
    return b;
  endfunction

endpackage

// File: rtl/lru_rank_stack.sv
`timescale 1ns/1ps
module lru_rank_stack #(
  parameter int WAYS  = 16,
  parameter int POS_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_en,
  input  logic [POS_W-1:0]      touch_way,
  output logic [WAYS*POS_W-1:0] pos_flat
);

  logic [POS_W-1:0] rank_q [WAYS];
  logic [POS_W-1:0] old_rank;

  assign old_rank = rank_q[touch_way];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic is_me;
    assign is_me = (touch_way == POS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q[g] <= POS_W'(g);
      end else if (touch_en) begin
        if (is_me)
          rank_q[g] <= POS_W'(WAYS - 1);
        else if (rank_q[g] > old_rank)
          rank_q[g] <= rank_q[g] - 1'b1;
      end
    end

    assign pos_flat[g*POS_W +: POS_W] = rank_q[g];
  end

endmodule

// File: rtl/lru_cost_store.sv
`timescale 1ns/1ps
module lru_cost_store #(
  parameter int WAYS   = 16,
  parameter int COST_W = 3,
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [COST_W-1:0]      wr_cost,
  output logic [WAYS*COST_W-1:0] cost_flat
);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [COST_W-1:0] cost_q;
    logic              wr_me;
    assign wr_me = wr_en && (wr_way == WAY_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cost_q <= '0;
      else if (wr_me)
        cost_q <= wr_cost;
    end

    assign cost_flat[g*COST_W +: COST_W] = cost_q;
  end

endmodule

// File: rtl/lru_victim_pick.sv
`timescale 1ns/1ps
module lru_victim_pick #(
  parameter int WAYS    = 16,
  parameter int COST_W  = 3,
  parameter int WT_W    = 3,
  parameter int POS_W   = $clog2(WAYS),
  parameter int SCORE_W = lru_cost_pkg::score_bits(WAYS, COST_W, WT_W)
) (
  input  logic [WAYS*POS_W-1:0]  pos_flat,
  input  logic [WAYS*COST_W-1:0] cost_flat,
  input  logic                   lin_mode,
  input  logic [WT_W-1:0]        weight,
  output logic [POS_W-1:0]       victim
);

  function automatic logic [SCORE_W-1:0] way_score(
    input logic [POS_W-1:0]  p,
    input logic [COST_W-1:0] c,
    input logic [WT_W-1:0]   w,
    input logic              lin
  );
    logic [SCORE_W-1:0] prod;
    prod = SCORE_W'(c) * SCORE_W'(w);
    return lin ? (SCORE_W'(p) + prod) : SCORE_W'(p);
  endfunction

  logic [SCORE_W-1:0] score [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_score
    assign score[g] = way_score(pos_flat[g*POS_W +: POS_W],
                                cost_flat[g*COST_W +: COST_W],
                                weight, lin_mode);
  end

  // Strict less-than while scanning upward keeps ties on the lowest way.
  logic [SCORE_W-1:0] best_s;
  logic [POS_W-1:0]   best_w;

  always_comb begin
    best_s = score[0];
    best_w = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (score[i] < best_s) begin
        best_s = score[i];
        best_w = POS_W'(i);
      end
    end
  end

  assign victim = best_w;

endmodule

// File: rtl/lru_cost_victim.sv
`timescale 1ns/1ps
module lru_cost_victim #(
  parameter int WAYS   = 16,
  parameter int COST_W = 3,
  parameter int WT_W   = 3,
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [WAY_W-1:0]  acc_way,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [COST_W-1:0] fill_cost,
  input  logic              cost_mode,
  input  logic [WT_W-1:0]   cost_weight,
  output logic [WAY_W-1:0]  victim_way
);
  import lru_cost_pkg::*;

  // Named internal events, brought out for the checker.
  logic                   touch_en;
  logic [WAY_W-1:0]       touch_way;
  logic [WAYS*WAY_W-1:0]  pos_flat;
  logic [WAYS*COST_W-1:0] cost_flat;
  policy_e                policy;

  assign touch_en  = acc_en | fill_en;
  assign touch_way = fill_en ? fill_way : acc_way;
  assign policy    = policy_e'(cost_mode);

  lru_rank_stack #(.WAYS(WAYS), .POS_W(WAY_W)) u_rank (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_way(touch_way),
    .pos_flat(pos_flat)
  );

  lru_cost_store #(.WAYS(WAYS), .COST_W(COST_W), .WAY_W(WAY_W)) u_cost (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_en), .wr_way(fill_way), .wr_cost(fill_cost),
    .cost_flat(cost_flat)
  );

  lru_victim_pick #(.WAYS(WAYS), .COST_W(COST_W), .WT_W(WT_W), .POS_W(WAY_W)) u_pick (
    .pos_flat(pos_flat), .cost_flat(cost_flat),
    .lin_mode(policy == POL_LIN), .weight(cost_weight),
    .victim(victim_way)
  );

endmodule

// File: rtl/lru_cost_chk.sv
`timescale 1ns/1ps
module lru_cost_chk #(
  parameter int WAYS   = 16,
  parameter int COST_W = 3,
  parameter int WT_W   = 3,
  parameter int WAY_W  = $clog2(WAYS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_en,
  input logic [WAY_W-1:0]       acc_way,
  input logic                   fill_en,
  input logic [WAY_W-1:0]       fill_way,
  input logic [COST_W-1:0]      fill_cost,
  input logic                   cost_mode,
  input logic [WT_W-1:0]        cost_weight,
  input logic [WAY_W-1:0]       victim_way,
  input logic [WAYS*WAY_W-1:0]  pos_flat,
  input logic [WAYS*COST_W-1:0] cost_flat
);

  function automatic int rank_of(input logic [WAYS*WAY_W-1:0] f, input int w);
    return int'(f[w*WAY_W +: WAY_W]);
  endfunction

  function automatic int cost_of(input logic [WAYS*COST_W-1:0] f, input int w);
    return int'(f[w*COST_W +: COST_W]);
  endfunction

  // Ranks must always be a permutation of 0..WAYS-1.
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[rank_of(pos_flat, i)] = 1'b1;
  end

  // Linear-rule victim: minimal score, and no lower way shares it.
  logic lin_ok;
  always_comb begin
    int vs;
    int s;
    vs = rank_of(pos_flat, int'(victim_way)) + int'(cost_weight) * cost_of(cost_flat, int'(victim_way));
    lin_ok = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      s = rank_of(pos_flat, i) + int'(cost_weight) * cost_of(cost_flat, i);
      if (s < vs) lin_ok = 1'b0;
      if (i < int'(victim_way) && s == vs) lin_ok = 1'b0;
    end
  end

  a_r2_rank_perm: assert property (@(posedge clk) disable iff (!rst_n) &seen);

  a_r2_touch_top: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en || fill_en) |=> rank_of(pos_flat, int'($past(fill_en ? fill_way : acc_way))) == WAYS - 1);

  a_r3_lru_victim: assert property (@(posedge clk) disable iff (!rst_n)
    !cost_mode |-> rank_of(pos_flat, int'(victim_way)) == 0);

  a_r4_lin_victim: assert property (@(posedge clk) disable iff (!rst_n)
    cost_mode |-> lin_ok); // also R5

  a_r6_hit_keeps_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !fill_en) |=> $stable(cost_flat));

  a_r6_fill_writes: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> cost_of(cost_flat, int'($past(fill_way))) == int'($past(fill_cost)));

  a_r7_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && fill_en && acc_way != fill_way) |=> rank_of(pos_flat, int'($past(acc_way))) != WAYS - 1);

endmodule

bind lru_cost_victim lru_cost_chk #(
  .WAYS(WAYS), .COST_W(COST_W), .WT_W(WT_W), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_en(acc_en), .acc_way(acc_way),
  .fill_en(fill_en), .fill_way(fill_way), .fill_cost(fill_cost),
  .cost_mode(cost_mode), .cost_weight(cost_weight),
  .victim_way(victim_way),
  .pos_flat(pos_flat), .cost_flat(cost_flat)
);

// File: tb/sim_lru_cost_victim.sv
`timescale 1ns/1ps
module sim_lru_cost_victim;

  localparam int NW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic [3:0] acc_way = '0;
  logic       fill_en = 1'b0;
  logic [3:0] fill_way = '0;
  logic [2:0] fill_cost = '0;
  logic       cost_mode = 1'b0;
  logic [2:0] cost_weight = '0;
  logic [3:0] victim_way;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  int mrank [NW];
  int mcost [NW];

  always #4 clk = ~clk;

  lru_cost_victim u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_way(acc_way),
    .fill_en(fill_en), .fill_way(fill_way), .fill_cost(fill_cost),
    .cost_mode(cost_mode), .cost_weight(cost_weight),
    .victim_way(victim_way)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) begin
      mrank[i] = i;
      mcost[i] = 0;
    end
  endtask

  task automatic model_touch(input int w);
    int old;
    old = mrank[w];
    for (int i = 0; i < NW; i++) begin
      if (i == w) mrank[i] = NW - 1;
      else if (mrank[i] > old) mrank[i] = mrank[i] - 1;
    end
  endtask

  // Two passes: find the smallest score, then the first way reaching it.
  function automatic int exp_victim(input int lin, input int wt);
    int best;
    int s;
    best = 1 << 20;
    for (int i = 0; i < NW; i++) begin
      s = mrank[i] + (lin != 0 ? wt * mcost[i] : 0);
      if (s < best) best = s;
    end
    for (int i = 0; i < NW; i++) begin
      s = mrank[i] + (lin != 0 ? wt * mcost[i] : 0);
      if (s == best) return i;
    end
    return -1;
  endfunction

  // Victim is combinational (R8): change rule/weight between edges and sample.
  task automatic sweep(input string tag);
    cost_mode = 1'b0;
    cost_weight = 3'd5;
    #1;
    check(int'(victim_way), exp_victim(0, 0), {tag, " R3 lru"});
    for (int w = 0; w < 8; w++) begin
      cost_mode = 1'b1;
      cost_weight = 3'(w);
      #1;
      check(int'(victim_way), exp_victim(1, w), {tag, " R4 R5 R8 linear"});
    end
  endtask

  task automatic do_op(input bit a, input int aw, input bit f, input int fw, input int fc);
    @(negedge clk);
    acc_en = a;
    acc_way = 4'(aw);
    fill_en = f;
    fill_way = 4'(fw);
    fill_cost = 3'(fc);
    @(negedge clk);
    acc_en = 1'b0;
    fill_en = 1'b0;
    if (f) begin
      model_touch(fw);
      mcost[fw] = fc;
    end else if (a) begin
      model_touch(aw);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);

    // R1: during reset
    cost_mode = 1'b0;
    #1 check(int'(victim_way), 0, "R1 in reset lru");
    cost_mode = 1'b1;
    cost_weight = 3'd7;
    #1 check(int'(victim_way), 0, "R1 in reset linear");
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 after release");

    // R2: one hit on way 0, then stack order read out through LRU victim
    do_op(1, 0, 0, 0, 0);
    cost_mode = 1'b0;
    #1 check(int'(victim_way), 1, "R2 hit way0 drops way1 to rank0");
    sweep("R2");

    // R5: forced tie. way1 rank0 cost1, way0 rank1 cost0.
    do_reset();
    do_op(0, 0, 1, 1, 1);
    do_op(0, 0, 1, 0, 0);
    for (int w = 2; w < NW; w++) do_op(1, w, 0, 0, 0);
    cost_mode = 1'b1;
    cost_weight = 3'd1;
    #1 check(int'(victim_way), 0, "R5 tie to lowest way");
    cost_weight = 3'd0;
    #1 check(int'(victim_way), 1, "R8 weight0 no clock");
    cost_weight = 3'd2;
    #1 check(int'(victim_way), 0, "R8 weight2 no clock");
    sweep("R5");

    // R6: cost 7 survives a hit on the same way
    do_reset();
    do_op(0, 0, 1, 0, 7);
    do_op(1, 0, 0, 0, 0);
    for (int w = 1; w < NW; w++) do_op(1, w, 0, 0, 0);
    cost_mode = 1'b0;
    #1 check(int'(victim_way), 0, "R6 lru way0 rank0");
    cost_mode = 1'b1;
    cost_weight = 3'd1;
    #1 check(int'(victim_way), 1, "R6 hit kept cost 7");
    sweep("R6");

    // R7: simultaneous hit on 5 and fill on 9
    do_reset();
    do_op(1, 5, 1, 9, 3);
    for (int w = 0; w < NW; w++) if (w != 5 && w != 9) do_op(1, w, 0, 0, 0);
    cost_mode = 1'b0;
    #1 check(int'(victim_way), 5, "R7 hit ignored under fill");
    cost_mode = 1'b1;
    cost_weight = 3'd7;
    #1 check(int'(victim_way), 5, "R7 linear cost of way9 kept");
    sweep("R7");

    // Pseudo-random stream: hits, fills, both at once
    do_reset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      int kind;
      int aw;
      int fw;
      int fc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      kind = int'(lfsr[1:0]);
      aw = int'(lfsr[5:2]);
      fw = int'(lfsr[9:6]);
      fc = int'(lfsr[12:10]);
      case (kind)
        0, 1: begin do_op(1, aw, 0, 0, 0); sweep("R2 R6 hit"); end
        2:    begin do_op(0, 0, 1, fw, fc); sweep("R2 R6 fill"); end
        default: begin do_op(1, aw, 1, fw, fc); sweep("R7 both"); end
      endcase
    end

    summary_and_end();
  end

endmodule